// File: doc/BRIEF.md
# Audio Subframe Framer

This block sits between a software-fed word stream and a bi-phase line coder on a consumer digital audio output. Software hands over one 32-bit word per subframe on a ready/valid stream. The block keeps track of where each subframe falls within a block of frames and marks each subframe with a preamble tag, B, M or W. It clears the four preamble slots and puts a freshly computed parity bit into the last slot. Every other slot is copied from the software word as it stands.

The line coder paces the block with a single-cycle strobe, one per bit slot, which normally arrives every second clock cycle. On each strobe the block presents the next slot bit and its slot index. The preamble tag is held for the whole subframe. The bit order taken from the memory word can be set to LSB first or MSB first. A restart input makes the next subframe begin a new block. If software has no word ready when a subframe must start, the block sends an all-zero payload under the correct preamble and flags an underrun.

Top module: `subframeFramer`

## Requirements
- R1: After reset, preTag is 00 (idle), slotBit is 0, slotIdx is 0, underrun is 0 and wordReady is 0 while slotStrobe is low.
- R2: Each slotStrobe pulse advances slotIdx by one within a subframe, with the new slotBit visible after that clock edge. Without a strobe, slotIdx, slotBit and preTag hold their values.
- R3: The preTag encoding is B=01, M=10 and W=11. Subframe 0 of a block is tagged B, other even subframes M, and odd subframes W. The subframe count wraps to 0 after 2*FRAMES subframes.
- R4: With msbFirst=0, slot k (4..30) carries word bit k. With msbFirst=1, slot k carries word bit 31-k. Slots 28, 29 and 30 (validity, user, channel status) follow the same mapping with no change.
- R5: Slots 0 to 3, the preamble field, are always output as 0. The line coder builds the preamble from preTag.
- R6: Slot 31 is generated so that the number of ones across slots 4 to 31 is even. The input bit that maps to slot 31 is ignored.
- R7: wordReady is high only in a cycle where slotStrobe starts a new subframe, which is at slotIdx 31 or when idle. A word is taken on wordReady && wordValid.
- R8: If wordValid is low when a subframe starts, that subframe carries an all-zero payload with the correct tag, and underrun is held high for the whole subframe.
- R9: A pulse on restart makes the next subframe to start carry B, and counting continues from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordData | input | 32 | Subframe word from software |
| wordValid | input | 1 | wordData is valid |
| wordReady | output | 1 | Word accepted in this cycle |
| msbFirst | input | 1 | 1: slot 0 maps to word bit 31; 0: slot 0 maps to word bit 0 |
| restart | input | 1 | Start a new block at the next subframe |
| slotStrobe | input | 1 | Advance request from the line coder |
| slotBit | output | 1 | Current slot bit |
| slotIdx | output | 5 | Current slot index, 0..31 |
| preTag | output | 2 | Preamble tag of the current subframe |
| underrun | output | 1 | Current subframe was filled with zeros |

## Verification
The bench builds the framer with FRAMES set to 4, so a block holds eight subframes. The vector walk therefore crosses the block boundary and shows the B tag returning after the wrap, which a 192-frame block would only reach after hundreds of subframes. The vectors mix both bit orders, words whose parity input bit disagrees with the computed parity, and empty-stream entries. Directed tests then cover a restart issued mid-block and a long stretch with no strobe.

// File: rtl/sfPkg.sv
package sfPkg;
  typedef enum logic [1:0] {
    TAG_IDLE = 2'b00,
    TAG_B    = 2'b01,
    TAG_M    = 2'b10,
    TAG_W    = 2'b11
  } preTagT;

  typedef struct packed {
    logic load;      // capture a new subframe
    logic shift;     // move to next slot
    logic zeroFill;  // load zeros instead of the input word
  } ctrlStbT;
endpackage

// File: rtl/sfCtrl.sv
module sfCtrl
  import sfPkg::*;
#(
  parameter int FRAMES = 192,
  parameter int SLOTS  = 32,
  localparam int SUBS   = 2 * FRAMES,
  localparam int IDX_W  = $clog2(SUBS),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotStrobe,
  input  logic              wordValid,
  input  logic              restart,
  output ctrlStbT           stb,
  output logic              wordReady,
  output preTagT            preTag,
  output logic [SLOT_W-1:0] slotIdx,
  output logic              underrun
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [IDX_W-1:0]  LAST_SUB  = IDX_W'(SUBS - 1);

  logic             active;
  logic             restartPend;
  logic [IDX_W-1:0] subIdx;
  logic [IDX_W-1:0] nextIdx;
  logic             startSf;

  assign active  = (preTag != TAG_IDLE);
  assign startSf = slotStrobe && (!active || slotIdx == LAST_SLOT);

  always_comb begin
    if (restartPend || restart || !active) nextIdx = '0;
    else if (subIdx == LAST_SUB)           nextIdx = '0;
    else                                   nextIdx = subIdx + IDX_W'(1);
  end

  assign stb.load     = startSf;
  assign stb.shift    = slotStrobe && !startSf;
  assign stb.zeroFill = !wordValid;
  assign wordReady    = startSf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preTag      <= TAG_IDLE;
      slotIdx     <= '0;
      subIdx      <= '0;
      restartPend <= 1'b0;
      underrun    <= 1'b0;
    end else begin
      if (startSf) begin
        subIdx      <= nextIdx;
        slotIdx     <= '0;
        underrun    <= !wordValid;
        restartPend <= 1'b0;
        if (nextIdx == '0)      preTag <= TAG_B;
        else if (nextIdx[0])    preTag <= TAG_W;
        else                    preTag <= TAG_M;
      end else begin
        if (restart) restartPend <= 1'b1;
        if (slotStrobe) slotIdx <= slotIdx + SLOT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sfData.sv
module sfData
  import sfPkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int PRE_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStbT          stb,
  input  logic             msbFirst,
  input  logic [SLOTS-1:0] wordData,
  output logic             slotBit
);
  logic [SLOTS-1:0] lsbVec;
  logic [SLOTS-1:0] msbVec;
  logic [SLOTS-1:0] ordered;
  logic [SLOTS-1:0] framed;
  logic [SLOTS-1:0] shReg;

  for (genvar k = 0; k < SLOTS; k++) begin : g_order
    assign lsbVec[k] = wordData[k];
    assign msbVec[k] = wordData[SLOTS-1-k];
  end

  assign ordered = msbFirst ? msbVec : lsbVec;

  always_comb begin
    framed = stb.zeroFill ? '0 : ordered;
    framed[PRE_W-1:0] = '0;
    framed[SLOTS-1]   = ^framed[SLOTS-2:PRE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN)          shReg <= '0;
    else if (stb.load)  shReg <= framed;
    else if (stb.shift) shReg <= {1'b0, shReg[SLOTS-1:1]};
  end

  assign slotBit = shReg[0];
endmodule

// File: rtl/subframeFramer.sv
module subframeFramer
  import sfPkg::*;
#(
  parameter int FRAMES = 192
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] wordData,
  input  logic        wordValid,
  output logic        wordReady,
  input  logic        msbFirst,
  input  logic        restart,
  input  logic        slotStrobe,
  output logic        slotBit,
  output logic [4:0]  slotIdx,
  output logic [1:0]  preTag,
  output logic        underrun
);
  localparam int SLOTS = 32;
  localparam int PRE_W = 4;

  ctrlStbT stb;
  preTagT  tagInt;

  sfCtrl #(.FRAMES(FRAMES), .SLOTS(SLOTS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .slotStrobe(slotStrobe),
    .wordValid (wordValid),
    .restart   (restart),
    .stb       (stb),
    .wordReady (wordReady),
    .preTag    (tagInt),
    .slotIdx   (slotIdx),
    .underrun  (underrun)
  );

  sfData #(.SLOTS(SLOTS), .PRE_W(PRE_W)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .msbFirst(msbFirst),
    .wordData(wordData),
    .slotBit (slotBit)
  );

  assign preTag = tagInt;
endmodule

// File: rtl/subframeFramerChk.sv
module subframeFramerChk (
  input logic       clk,
  input logic       rstN,
  input logic       slotStrobe,
  input logic       wordReady,
  input logic       restart,
  input logic       slotBit,
  input logic [4:0] slotIdx,
  input logic [1:0] preTag,
  input logic       underrun
);
  a_r7_ready_on_start: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> (slotStrobe && (preTag == 2'b00 || slotIdx == 5'd31)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !slotStrobe |=> ($stable(slotIdx) && $stable(slotBit) && $stable(preTag)));

  a_r2_advance: assert property (@(posedge clk) disable iff (!rstN)
    (slotStrobe && preTag != 2'b00 && slotIdx != 5'd31) |=> slotIdx == $past(slotIdx) + 5'd1);

  a_r5_preamble_zero: assert property (@(posedge clk) disable iff (!rstN)
    (preTag != 2'b00 && slotIdx < 5'd4) |-> !slotBit);

  a_r3_after_w: assert property (@(posedge clk) disable iff (!rstN)
    (wordReady && preTag == 2'b11) |=> preTag != 2'b11);

  a_r8_zero_payload: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> !slotBit);

  a_r9_restart_b: assert property (@(posedge clk) disable iff (!rstN)
    (wordReady && restart) |=> preTag == 2'b01);
endmodule

bind subframeFramer subframeFramerChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .slotStrobe(slotStrobe),
  .wordReady (wordReady),
  .restart   (restart),
  .slotBit   (slotBit),
  .slotIdx   (slotIdx),
  .preTag    (preTag),
  .underrun  (underrun)
);

// File: tb/sim_subframeFramer.sv
module sim_subframeFramer;
  localparam int FRAMES = 4;
  localparam int SUBS   = 2 * FRAMES;
  localparam int NVEC   = 12;

  // {valid, msbFirst, word}
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 32'h8765_4321},
    {1'b1, 1'b0, 32'h0000_0010},
    {1'b1, 1'b1, 32'hF00D_CAFE},
    {1'b0, 1'b0, 32'hFFFF_FFFF},
    {1'b1, 1'b1, 32'h0000_0008},
    {1'b1, 1'b0, 32'h7000_0000},
    {1'b1, 1'b0, 32'hFFFF_FFFF},
    {1'b1, 1'b1, 32'h1234_5678},
    {1'b1, 1'b0, 32'hA5A5_A5A5},
    {1'b0, 1'b1, 32'h1111_1111},
    {1'b1, 1'b1, 32'hFFFF_FFF0},
    {1'b1, 1'b0, 32'h0F0F_0F0F}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] wordData = '0;
  logic        wordValid = 1'b0;
  logic        wordReady;
  logic        msbFirst = 1'b0;
  logic        restart = 1'b0;
  logic        slotStrobe = 1'b0;
  logic        slotBit;
  logic [4:0]  slotIdx;
  logic [1:0]  preTag;
  logic        underrun;

  int compared = 0;
  int mismatched = 0;
  int nextSub = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  subframeFramer #(.FRAMES(FRAMES)) u0 (
    .clk(clk), .rstN(rstN), .wordData(wordData), .wordValid(wordValid),
    .wordReady(wordReady), .msbFirst(msbFirst), .restart(restart),
    .slotStrobe(slotStrobe), .slotBit(slotBit), .slotIdx(slotIdx),
    .preTag(preTag), .underrun(underrun)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expSlots(input logic [31:0] w, input logic msb, input logic vld);
    logic [31:0] s;
    s = '0;
    for (int k = 4; k < 31; k++) s[k] = vld ? (msb ? w[31-k] : w[k]) : 1'b0;
    for (int k = 4; k < 31; k++) s[31] = s[31] ^ s[k];
    return s;
  endfunction

  function automatic logic [1:0] expTag(input int idx);
    if (idx == 0) return 2'b01;
    return idx[0] ? 2'b11 : 2'b10;
  endfunction

  // Run one full subframe: 32 strobes, one every second cycle.
  task automatic runSub(input logic [31:0] w, input logic msb, input logic vld, input string tagReq);
    logic [31:0] got;
    logic [1:0]  tag;
    logic        und;
    logic        rdyStart;
    logic        rdyMid;
    logic        idxOk;
    got = '0; idxOk = 1'b1; rdyStart = 1'b0; rdyMid = 1'b0; tag = '0; und = 1'b0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (k == 0) begin wordData = w; msbFirst = msb; wordValid = vld; end
      slotStrobe = 1'b1;
      #1;
      if (k == 0) rdyStart = wordReady;
      if (k == 5) rdyMid = wordReady;
      @(negedge clk);
      slotStrobe = 1'b0;
      wordValid = 1'b0;
      got[k] = slotBit;
      if (slotIdx != 5'(k)) idxOk = 1'b0;
      if (k == 0) begin tag = preTag; und = underrun; end
    end
    check("R4/R5/R6 slot bits", 64'(got), 64'(expSlots(w, msb, vld)));
    check(tagReq, 64'(tag), 64'(expTag(nextSub)));
    check("R8 underrun flag", 64'(und), 64'(!vld));
    check("R2 slotIdx sequence", 64'(idxOk), 64'd1);
    check("R7 wordReady start/mid", 64'({rdyStart, rdyMid}), 64'b10);
    nextSub = (nextSub + 1) % SUBS;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 preTag idle", 64'(preTag), 64'd0);
    check("R1 slotBit", 64'(slotBit), 64'd0);
    check("R1 slotIdx", 64'(slotIdx), 64'd0);
    check("R1 underrun", 64'(underrun), 64'd0);
    check("R1 wordReady", 64'(wordReady), 64'd0);

    // Vector walk: crosses the block wrap (R3) at entry 8
    for (int i = 0; i < NVEC; i++)
      runSub(VEC[i][31:0], VEC[i][32], VEC[i][33], "R3 tag sequence");

    // R9: restart issued mid-subframe
    begin
      logic [31:0] w;
      w = 32'h5555_AAAA;
      for (int k = 0; k < 32; k++) begin
        @(negedge clk);
        if (k == 0) begin wordData = w; msbFirst = 1'b0; wordValid = 1'b1; end
        slotStrobe = 1'b1;
        @(negedge clk);
        slotStrobe = 1'b0;
        wordValid = 1'b0;
        if (k == 10) begin
          restart = 1'b1;
          @(negedge clk);
          restart = 1'b0;
        end
      end
      nextSub = 0;
      runSub(32'hDEAD_BEEF, 1'b1, 1'b1, "R9 B after restart");
      runSub(32'h0BAD_F00D, 1'b0, 1'b1, "R9 W after restart B");
    end

    // R2: no strobe, outputs hold
    begin
      logic [4:0] i0;
      logic [1:0] t0;
      logic       b0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (k == 0) begin wordData = 32'h0000_0FF0; msbFirst = 1'b0; wordValid = 1'b1; end
        slotStrobe = 1'b1;
        @(negedge clk);
        slotStrobe = 1'b0;
        wordValid = 1'b0;
      end
      i0 = slotIdx; t0 = preTag; b0 = slotBit;
      repeat (12) @(negedge clk);
      check("R2 hold without strobe", 64'({slotIdx, preTag, slotBit}), 64'({i0, t0, b0}));
      check("R2 hold slotIdx value", 64'(slotIdx), 64'd2);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule